// File: doc/BRIEF.md
# Commutation State Tracker

This block follows the electrical commutation step of a brushless DC motor using an angular position count supplied from outside. The current step owns a window of positions, bounded below and above. Each evaluation adds a host-chosen angle shift to the position and tests the sum against that window. If the sum has left the window, the block moves one step up or down, wrapping at either end of the sequence. It then derives the new window from the length of the step it has just entered.

A small host-written table holds one entry per step: a length in position counts and an output pin pattern. Evaluations come from one of three sources: an internal interval timer in periodic mode, an external event strobe in event mode, or an immediate host update command. A second event mode and a host force command skip the window tests and simply present the current step's pattern. The host can preload the step number and both window edges. A one-cycle done pulse marks every action the block takes.

Top module: `comm_tracker`

## Requirements
- R1: Each table entry is 16 bits. Bits 15:8 give the step length and bits 7:0 give the pin pattern. A table write is seen by any evaluation or force in a later cycle.
- R2: An evaluation forms v = pos + offset, then d = v − lower and span = upper − lower, all modulo 2^16. If d is negative as a 16-bit two's-complement value, v is below the window. Otherwise, if d < span (signed), v is inside: the step and both edges stay unchanged and pins_o is reloaded with the current step's pattern.
- R3: When v is below the window, the step number decreases by one, and step 0 wraps to num_states−1. The new upper edge is the old lower edge. The new lower edge is the old lower edge minus the length of the newly entered step. pins_o takes the new step's pattern.
- R4: When v is at or above the window, the step number increases by one, and reaching num_states wraps to 0. The new lower edge is the old upper edge. The new upper edge is the old upper edge plus the length of the newly entered step. pins_o takes the new step's pattern.
- R5: An evaluation moves at most one step, however far v lies outside the window.
- R6: The mode input selects the behaviour. When mode bit 1 is 0 (codes 00 and 01), the block is in periodic mode and evt_i is ignored. Code 10 makes evt_i run an evaluation. Code 11 makes evt_i run a force.
- R7: Host command 11 (update) evaluates at once. In periodic mode it also starts the interval timer, which then evaluates every period_i cycles (period_i ≥ 1) until the timer is stopped.
- R8: Host command 10 (force) loads pins_o with the current step's pattern, leaves the step number and edges unchanged, and stops the interval timer. Commands 00 and 01 do nothing.
- R9: In mode 11, evt_i forces the current step's pattern onto pins_o with no window test, so the step number and edges do not change.
- R10: An init write loads the step number, lower edge and upper edge from the init inputs and leaves pins_o unchanged.
- R11: done_o is high for exactly the one cycle after each evaluation, force or init write, and low otherwise.
- R12: Within one cycle, an init write overrides any host command, and a host command (10 or 11) overrides evt_i and the interval timer.
- R13: Synchronous reset clears the step number, both edges, pins_o, done_o and the table, and stops the interval timer. All results are registered and appear after the clock edge that samples their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_i | input | 16 | External angular position count |
| offset_i | input | 16 | Host angle shift added to the position |
| num_states_i | input | CNT_W | Number of steps in the sequence (1..MAX_STATES) |
| mode_i | input | 2 | Mode select: 0x periodic, 10 event test, 11 event force |
| evt_i | input | 1 | Event strobe |
| period_i | input | TIMER_W | Interval between periodic evaluations, in cycles |
| host_cmd_i | input | 2 | Host command: 10 force, 11 update, others none |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | IDX_W | Table write index |
| tbl_data_i | input | 16 | Table entry {length, pattern} |
| init_we_i | input | 1 | Load step number and edges |
| init_state_i | input | IDX_W | Step number to load |
| init_lower_i | input | 16 | Lower edge to load |
| init_upper_i | input | 16 | Upper edge to load |
| state_o | output | IDX_W | Current step number |
| lower_o | output | 16 | Current lower edge |
| upper_o | output | 16 | Current upper edge |
| pins_o | output | 8 | Pin pattern of the last presented step |
| done_o | output | 1 | One-cycle pulse after each action |

## Verification
The assertions assume the host keeps num_states_i between 1 and MAX_STATES and keeps the step number below it. They also assume windows narrower than half the 16-bit range, so that the signed window test is meaningful. The stimulus follows these rules: it loads a consistent step and window for every sequence length before it sends any event. It draws positions from a bounded band around the live window, plus a few far jumps that stay within the signed range. It uses a nonzero period for every periodic run.

// File: rtl/comm_pkg.sv
package comm_pkg;

    localparam int POS_W   = 16;
    localparam int LEN_W   = 8;
    localparam int PAT_W   = 8;
    localparam int ENTRY_W = LEN_W + PAT_W;

    typedef logic [POS_W-1:0] pos_t;

    // table entry: length in the high byte, pin pattern in the low byte
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [PAT_W-1:0] pat;
    } entry_t;

    typedef struct packed {
        pos_t lower;
        pos_t upper;
    } window_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'b00,
        CMD_SPARE  = 2'b01,
        CMD_FORCE  = 2'b10,
        CMD_UPDATE = 2'b11
    } hcmd_e;

    function automatic pos_t edge_grow(pos_t base, logic [LEN_W-1:0] len);
        return base + pos_t'(len);
    endfunction

    function automatic pos_t edge_shrink(pos_t base, logic [LEN_W-1:0] len);
        return base - pos_t'(len);
    endfunction

endpackage

// File: rtl/comm_table.sv
module comm_table
    import comm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  entry_t           wdata,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] nxt_idx,
    output entry_t           cur_entry,
    output entry_t           nxt_entry
);

    entry_t cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= '0;
            end else if (we && (waddr == IDX_W'(g))) begin
                cells[g] <= wdata;
            end
        end
    end

    always_comb begin
        cur_entry = '0;
        nxt_entry = '0;
        if (int'(cur_idx) < DEPTH) cur_entry = cells[cur_idx];
        if (int'(nxt_idx) < DEPTH) nxt_entry = cells[nxt_idx];
    end

endmodule

// File: rtl/comm_window.sv
module comm_window
    import comm_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  pos_t             pos_i,
    input  pos_t             offset_i,
    input  window_t          win_i,
    input  logic [IDX_W-1:0] state_i,
    input  logic [CNT_W-1:0] nstates_i,
    output step_e            step_o,
    output logic [IDX_W-1:0] next_o
);

    pos_t             shifted;
    pos_t             rel;
    pos_t             span;
    logic [CNT_W-1:0] up_wide;

    always_comb begin
        shifted = pos_i + offset_i;
        rel     = shifted - win_i.lower;
        span    = win_i.upper - win_i.lower;

        if (rel[POS_W-1]) begin
            step_o = STEP_DOWN;
        end else if ($signed(rel) < $signed(span)) begin
            step_o = STEP_HOLD;
        end else begin
            step_o = STEP_UP;
        end

        up_wide = CNT_W'(state_i) + CNT_W'(1);

        unique case (step_o)
            STEP_UP:   next_o = (up_wide >= nstates_i) ? '0 : IDX_W'(up_wide);
            STEP_DOWN: next_o = (state_i == '0) ? IDX_W'(nstates_i - CNT_W'(1))
                                                : state_i - IDX_W'(1);
            default:   next_o = state_i;
        endcase
    end

endmodule

// File: rtl/comm_pacer.sv
module comm_pacer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  logic               disarm,
    input  logic [TIMER_W-1:0] period,
    output logic               tick
);

    logic               armed_q;
    logic [TIMER_W-1:0] cnt_q;
    logic [TIMER_W-1:0] limit;

    assign limit = (period == '0) ? '0 : period - TIMER_W'(1);
    assign tick  = armed_q && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (arm) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (disarm) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (armed_q) begin
            cnt_q <= tick ? '0 : cnt_q + TIMER_W'(1);
        end
    end

    // R7/R8: once stopped, the timer stays silent on the next cycle
    a_r8_disarm_silences: assert property (@(posedge clk) disable iff (rst)
        (disarm && !arm) |=> !tick);

    // R7: a fresh start never fires before a full interval of at least one cycle
    a_r7_restart_waits: assert property (@(posedge clk) disable iff (rst)
        (arm && period > TIMER_W'(1)) |=> !tick);

endmodule

// File: rtl/comm_tracker.sv
module comm_tracker
    import comm_pkg::*;
#(
    parameter int MAX_STATES = 8,
    parameter int TIMER_W    = 16,
    localparam int IDX_W = $clog2(MAX_STATES),
    localparam int CNT_W = $clog2(MAX_STATES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [POS_W-1:0]   pos_i,
    input  logic [POS_W-1:0]   offset_i,
    input  logic [CNT_W-1:0]   num_states_i,
    input  logic [1:0]         mode_i,
    input  logic               evt_i,
    input  logic [TIMER_W-1:0] period_i,
    input  logic [1:0]         host_cmd_i,
    input  logic               tbl_we_i,
    input  logic [IDX_W-1:0]   tbl_addr_i,
    input  logic [ENTRY_W-1:0] tbl_data_i,
    input  logic               init_we_i,
    input  logic [IDX_W-1:0]   init_state_i,
    input  logic [POS_W-1:0]   init_lower_i,
    input  logic [POS_W-1:0]   init_upper_i,
    output logic [IDX_W-1:0]   state_o,
    output logic [POS_W-1:0]   lower_o,
    output logic [POS_W-1:0]   upper_o,
    output logic [PAT_W-1:0]   pins_o,
    output logic               done_o
);

    // ---------------- registered state ----------------
    logic [IDX_W-1:0] state_q;
    window_t          win_q;
    logic [PAT_W-1:0] pins_q;
    logic             done_q;

    // ---------------- action decode ----------------
    hcmd_e cmd;
    logic  periodic_mode;
    logic  cmd_busy;
    logic  do_init, do_cmd_force, do_cmd_update;
    logic  do_evt_test, do_evt_force, do_tick;
    logic  do_eval, do_force;
    logic  tick;

    assign cmd           = hcmd_e'(host_cmd_i);
    assign periodic_mode = !mode_i[1];
    assign do_init       = init_we_i;
    assign cmd_busy      = !do_init && host_cmd_i[1];
    assign do_cmd_force  = !do_init && (cmd == CMD_FORCE);
    assign do_cmd_update = !do_init && (cmd == CMD_UPDATE);
    assign do_evt_test   = !do_init && !cmd_busy && evt_i && (mode_i == 2'b10);
    assign do_evt_force  = !do_init && !cmd_busy && evt_i && (mode_i == 2'b11);
    assign do_tick       = !do_init && !cmd_busy && tick && periodic_mode;
    assign do_eval       = do_cmd_update || do_evt_test || do_tick;
    assign do_force      = do_cmd_force || do_evt_force;

    // ---------------- interval timer ----------------
    comm_pacer #(.TIMER_W(TIMER_W)) u_pacer (
        .clk    (clk),
        .rst    (rst),
        .arm    (do_cmd_update && periodic_mode),
        .disarm (do_cmd_force || !periodic_mode),
        .period (period_i),
        .tick   (tick)
    );

    // ---------------- window test ----------------
    step_e            step;
    logic [IDX_W-1:0] next_state;

    comm_window #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_window (
        .pos_i     (pos_i),
        .offset_i  (offset_i),
        .win_i     (win_q),
        .state_i   (state_q),
        .nstates_i (num_states_i),
        .step_o    (step),
        .next_o    (next_state)
    );

    // ---------------- step table ----------------
    entry_t cur_entry;
    entry_t nxt_entry;

    comm_table #(.DEPTH(MAX_STATES)) u_table (
        .clk       (clk),
        .rst       (rst),
        .we        (tbl_we_i),
        .waddr     (tbl_addr_i),
        .wdata     (entry_t'(tbl_data_i)),
        .cur_idx   (state_q),
        .nxt_idx   (next_state),
        .cur_entry (cur_entry),
        .nxt_entry (nxt_entry)
    );

    // ---------------- next window ----------------
    window_t win_next;

    always_comb begin
        win_next = win_q;
        unique case (step)
            STEP_UP: begin
                win_next.lower = win_q.upper;
                win_next.upper = edge_grow(win_q.upper, nxt_entry.len);
            end
            STEP_DOWN: begin
                win_next.upper = win_q.lower;
                win_next.lower = edge_shrink(win_q.lower, nxt_entry.len);
            end
            default: win_next = win_q;
        endcase
    end

    // ---------------- state update ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            win_q   <= '0;
            pins_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= do_init || do_eval || do_force;
            if (do_init) begin
                state_q     <= init_state_i;
                win_q.lower <= init_lower_i;
                win_q.upper <= init_upper_i;
            end else if (do_eval) begin
                state_q <= next_state;
                win_q   <= win_next;
                pins_q  <= nxt_entry.pat;
            end else if (do_force) begin
                pins_q <= cur_entry.pat;
            end
        end
    end

    assign state_o = state_q;
    assign lower_o = win_q.lower;
    assign upper_o = win_q.upper;
    assign pins_o  = pins_q;
    assign done_o  = done_q;

    // ---------------- assertions ----------------
    a_r4_up_reuses_upper: assert property (@(posedge clk) disable iff (rst)
        (do_eval && step == STEP_UP) |=> (lower_o == $past(upper_o)));

    a_r3_down_reuses_lower: assert property (@(posedge clk) disable iff (rst)
        (do_eval && step == STEP_DOWN) |=> (upper_o == $past(lower_o)));

    a_r2_inside_holds: assert property (@(posedge clk) disable iff (rst)
        (do_eval && step == STEP_HOLD) |=>
            ($stable(state_o) && $stable(lower_o) && $stable(upper_o)));

    a_r8_force_keeps_position: assert property (@(posedge clk) disable iff (rst)
        (do_force && !do_eval && !do_init) |=>
            ($stable(state_o) && $stable(lower_o) && $stable(upper_o)));

    a_r10_init_keeps_pins: assert property (@(posedge clk) disable iff (rst)
        do_init |=> $stable(pins_o));

    a_r11_done_after_action: assert property (@(posedge clk) disable iff (rst)
        (do_init || do_eval || do_force) |=> done_o);

    a_r11_done_quiet: assert property (@(posedge clk) disable iff (rst)
        !(do_init || do_eval || do_force) |=> !done_o);

    a_r12_single_action: assert property (@(posedge clk) disable iff (rst)
        $countones({do_init, do_eval, do_force}) <= 1);

endmodule

// File: tb/comm_tracker_test.sv
`timescale 1ns/1ps
module comm_tracker_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pos = '0, off = '0, period = 16'd1;
    logic [3:0]  nst = 4'd1;
    logic [1:0]  mode = 2'b10, cmd = 2'b00;
    logic        evt = 1'b0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic        init_we = 1'b0;
    logic [2:0]  init_state = '0;
    logic [15:0] init_lo = '0, init_hi = '0;
    logic [2:0]  state_o;
    logic [15:0] lower_o, upper_o;
    logic [7:0]  pins_o;
    logic        done_o;

    comm_tracker uut (
        .clk(clk), .rst(rst), .pos_i(pos), .offset_i(off), .num_states_i(nst),
        .mode_i(mode), .evt_i(evt), .period_i(period), .host_cmd_i(cmd),
        .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
        .init_we_i(init_we), .init_state_i(init_state), .init_lower_i(init_lo),
        .init_upper_i(init_hi), .state_o(state_o), .lower_o(lower_o),
        .upper_o(upper_o), .pins_o(pins_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    int ncmp = 0;
    int nerr = 0;
    bit finished = 0;

    logic [7:0]  mlen [8];
    logic [7:0]  mpat [8];
    int          m_s;
    logic [15:0] m_lo, m_hi;
    logic [7:0]  m_pins;
    logic [31:0] lcg = 32'h1234_5678;

    task automatic chk(string req, string what, int act, int exp);
        ncmp++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(string req, logic exp_done);
        chk(req, "state", int'(state_o), m_s);
        chk(req, "lower", int'(lower_o), int'(m_lo));
        chk(req, "upper", int'(upper_o), int'(m_hi));
        chk(req, "pins", int'(pins_o), int'(m_pins));
        chk(req, "done", int'(done_o), int'(exp_done));
    endtask

    // expected evaluation result, from R2/R3/R4
    task automatic model_eval(logic [15:0] p, logic [15:0] o);
        logic [15:0] v, d, span;
        v    = p + o;
        d    = v - m_lo;
        span = m_hi - m_lo;
        if ($signed(d) < 0) begin
            m_s  = (m_s == 0) ? int'(nst) - 1 : m_s - 1;
            m_hi = m_lo;
            m_lo = m_lo - 16'(mlen[m_s]);
        end else if (!($signed(d) < $signed(span))) begin
            m_s  = (m_s + 1 >= int'(nst)) ? 0 : m_s + 1;
            m_lo = m_hi;
            m_hi = m_hi + 16'(mlen[m_s]);
        end
        m_pins = mpat[m_s];
    endtask

    task automatic write_tbl(int i, logic [7:0] len, logic [7:0] pat);
        tbl_we = 1'b1; tbl_addr = 3'(i); tbl_data = {len, pat};
        cyc();
        tbl_we = 1'b0;
        mlen[i] = len; mpat[i] = pat;
    endtask

    task automatic load(int s, logic [15:0] lo, logic [15:0] hi);
        init_we = 1'b1; init_state = 3'(s); init_lo = lo; init_hi = hi;
        cyc();
        init_we = 1'b0;
        m_s = s; m_lo = lo; m_hi = hi;
        check_all("R10", 1'b1);
    endtask

    task automatic event_eval(logic [15:0] p, logic [15:0] o, string req);
        pos = p; off = o; evt = 1'b1;
        cyc();
        evt = 1'b0;
        model_eval(p, o);
        check_all(req, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
            $finish;
        end
    end

    initial begin
        m_s = 0; m_lo = '0; m_hi = '0; m_pins = '0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R13: reset state
        check_all("R13", 1'b0);

        // R1: table contents
        for (int i = 0; i < 8; i++) write_tbl(i, 8'(8 + 5 * i), 8'(8'h11 * (i + 1)));
        chk("R11", "done after table write", int'(done_o), 0);

        // R2 R3 R4 R5: sweep every sequence length with event-mode tests
        mode = 2'b10;
        for (int n = 1; n <= 8; n++) begin
            nst = 4'(n);
            load(0, 16'h0100, 16'h0100 + 16'(mlen[0]));
            for (int k = 0; k < 40; k++) begin
                logic [15:0] p;
                lcg = lcg * 32'd1103515245 + 32'd12345;
                if (lcg[27:24] == 4'hF) p = m_lo + 16'h0800;
                else if (lcg[27:24] == 4'hE) p = m_lo - 16'h0800;
                else p = m_lo + 16'(lcg[22:16]) - 16'd60;
                event_eval(p, 16'(lcg[10:8]), (k % 3 == 0) ? "R3" : ((k % 3 == 1) ? "R4" : "R2"));
            end
        end

        // R5: a very distant position still moves one step only
        nst = 4'd8;
        load(2, 16'h0200, 16'h0200 + 16'(mlen[2]));
        event_eval(16'h3000, 16'h0000, "R5");
        chk("R5", "single step up", int'(state_o), 3);
        event_eval(16'h0010, 16'h0000, "R5");
        chk("R5", "single step down", int'(state_o), 2);

        // R7: periodic evaluation every 4 cycles after an update command
        mode = 2'b00; period = 16'd4; pos = 16'h4000; off = 16'h0000;
        load(0, 16'h0000, 16'(mlen[0]));
        cmd = 2'b11;
        cyc();
        cmd = 2'b00;
        model_eval(pos, off);
        check_all("R7", 1'b1);
        for (int m = 1; m <= 12; m++) begin
            cyc();
            if (m % 4 == 0) model_eval(pos, off);
            check_all("R7", (m % 4 == 0));
        end

        // R8: force presents current pattern and stops the timer
        write_tbl(m_s, mlen[m_s], 8'h5A);
        cmd = 2'b10;
        cyc();
        cmd = 2'b00;
        m_pins = 8'h5A;
        check_all("R8", 1'b1);
        for (int m = 0; m < 10; m++) begin
            cyc();
            check_all("R8", 1'b0);
        end

        // R6: event ignored in periodic mode
        evt = 1'b1;
        cyc();
        evt = 1'b0;
        check_all("R6", 1'b0);

        // R8: spare command has no effect
        cmd = 2'b01;
        cyc();
        cmd = 2'b00;
        check_all("R8", 1'b0);

        // R9: mode 11 event forces without testing
        mode = 2'b11;
        write_tbl(m_s, mlen[m_s], 8'hC3);
        evt = 1'b1; pos = 16'h7000;
        cyc();
        evt = 1'b0;
        m_pins = 8'hC3;
        check_all("R9", 1'b1);

        // R12: init beats an update command in the same cycle
        mode = 2'b10;
        init_we = 1'b1; init_state = 3'd5; init_lo = 16'h0500;
        init_hi = 16'h0500 + 16'(mlen[5]); cmd = 2'b11; pos = 16'h6000;
        cyc();
        init_we = 1'b0; cmd = 2'b00;
        m_s = 5; m_lo = 16'h0500; m_hi = 16'h0500 + 16'(mlen[5]);
        check_all("R12", 1'b1);

        // R12: force command beats an event in the same cycle
        cmd = 2'b10; evt = 1'b1;
        cyc();
        cmd = 2'b00; evt = 1'b0;
        m_pins = mpat[5];
        check_all("R12", 1'b1);

        // R11: pulse lasts one cycle
        cyc();
        check_all("R11", 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end

endmodule